// File: doc/BRIEF.md
# Dual-Carrier BPSK Transmit Modulator

This block builds the digital transmit waveform for a narrow-band power line modem. A serial bit stream comes in through a valid/ready handshake. Each bit is sent as one bit period of a sine carrier. A bit of value 1 keeps the carrier at its reference phase and a bit of value 0 turns it by half a cycle. The carrier comes from a phase accumulator that drives a quarter-wave sine table. The block gives an 8-bit signed sample on every clock for an external DAC, and a flag that stays high while a packet is on the line.

Two frequency plans are built in, and each belongs to a system clock. The general signalling band runs from a 10.0 MHz clock, with carriers at 132 kHz and 115 kHz and 5.4 kbit/s. The utility band runs from a 6.5536 MHz clock, with carriers at 86 kHz and 75 kHz and 3.6 kbit/s. The faster carrier of each band is the primary one. Whenever a blocked-channel input reports the primary frequency as unusable, the block moves to the slower carrier by itself. The band and the carrier are both captured when a packet starts and stay fixed until it ends.

Top module: `bpsk_dual_tx`

## Requirements
- R1: While reset is held low and on the first cycle after it, tx_active is 0, dac_sample is 0 and bit_ready is 1.
- R2: With band_sel=1 (general band, 10.0 MHz clock) and the primary carrier, the output is a 132 kHz sine: tuning word round(132000·2^24/10e6). Each bit lasts 1852 clocks.
- R3: With band_sel=1 and car_sel=1 (secondary), the carrier is 115 kHz, with the same 1852-clock bit.
- R4: With band_sel=0 (utility band, 6.5536 MHz clock), the carrier is 86 kHz (primary) or 75 kHz (car_sel=1), and each bit lasts 1820 clocks.
- R5: The 24-bit phase accumulator is cleared when a packet starts and advances by the tuning word on every cycle of the packet. A bit of 1 adds no phase offset; a bit of 0 adds half a cycle (2^23). The offset changes only at bit boundaries.
- R6: If primary_blocked is 1 in the cycle a packet starts, the secondary carrier is used whatever car_sel says.
- R7: Changes on band_sel, car_sel or primary_blocked while a packet is running do not affect that packet.
- R8: The first sample of a packet appears one clock after its first bit is accepted. tx_active is high for exactly bits × clocks-per-bit cycles, aligned with the samples. dac_sample is 0 whenever tx_active is low.
- R9: bit_ready is 1 while idle and on the last clock of each bit, and 0 on every other clock of a bit. A bit is taken when bit_valid and bit_ready are both 1. The packet ends at a bit boundary where bit_valid is 0.
- R10: dac_sample is two's complement with a peak of ±127 and never -128. Phase bits [23:22] pick the quadrant and bits [21:16] address a 64-entry quarter-wave table sampled at bin midpoints. Quadrants 1 and 3 read the table in reverse and quadrants 2 and 3 negate the value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (10.0 MHz general band, 6.5536 MHz utility band) |
| rst_n | input | 1 | Active-low synchronous reset |
| band_sel | input | 1 | 1 = general signalling band, 0 = utility band |
| car_sel | input | 1 | 0 = primary carrier, 1 = secondary carrier |
| primary_blocked | input | 1 | Primary carrier reported unusable; forces the secondary carrier |
| bit_valid | input | 1 | bit_data holds a bit to send |
| bit_data | input | 1 | Data bit |
| bit_ready | output | 1 | Block takes the offered bit on this clock |
| dac_sample | output | 8 | Signed sine sample for the DAC |
| tx_active | output | 1 | High while packet samples are on the output |

## Verification
The checker watches these properties on every clock:
- the output stays silent outside a packet;
- tx_active follows the internal busy state one cycle later;
- bit_ready is high when idle;
- the data bit and the tuning word hold steady within a packet;
- a blocked primary at packet start selects the secondary carrier;
- the most negative code never appears.

The actual carrier frequencies, the bit lengths, the half-cycle phase turn and the table mirroring are shown only by the bench. The bench compares every sample of every packet with a sine computed from the requirement frequencies and counts the cycles of tx_active against the expected bit length.

// File: rtl/bpsk_pkg.sv
package bpsk_pkg;

   // Carrier index: {band, secondary}
   typedef enum logic {BAND_UTILITY = 1'b0, BAND_GENERAL = 1'b1} band_e;

   // Rounded phase increment for a carrier at a given clock
   function automatic longint unsigned tune_word(input int unsigned f_hz,
                                                 input int unsigned clk_hz,
                                                 input int unsigned acc_w);
      longint unsigned num;
      num = (longint'(f_hz) << acc_w) + longint'(clk_hz / 2);
      return num / longint'(clk_hz);
   endfunction

   // Rounded clocks per data bit
   function automatic int unsigned clks_per_bit(input int unsigned clk_hz,
                                                input int unsigned bps);
      return (clk_hz + bps / 2) / bps;
   endfunction

   // Quarter-wave sine magnitude at the midpoint of bin idx,
   // rational approximation of sine over a half period of 4*depth units
   function automatic int quarter_sine(input int idx, input int depth, input int amp);
      int u;
      int p;
      int num;
      int den;
      u   = 2 * idx + 1;
      p   = 4 * depth;
      num = 4 * amp * u * (p - u);
      den = (5 * p * p) / 4 - u * (p - u);
      return (num + den / 2) / den;
   endfunction

endpackage

// File: rtl/bpsk_tune_sel.sv
module bpsk_tune_sel
   import bpsk_pkg::*;
#(
   parameter int unsigned PHASE_W     = 24,
   parameter int unsigned CPB_W       = 12,
   parameter int unsigned GEN_CLK_HZ  = 10_000_000,
   parameter int unsigned UTIL_CLK_HZ = 6_553_600,
   parameter int unsigned GEN_PRI_HZ  = 132_000,
   parameter int unsigned GEN_SEC_HZ  = 115_000,
   parameter int unsigned UTIL_PRI_HZ = 86_000,
   parameter int unsigned UTIL_SEC_HZ = 75_000,
   parameter int unsigned GEN_BPS     = 5400,
   parameter int unsigned UTIL_BPS    = 3600
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load_i,
   input  logic               band_i,
   input  logic               car_i,
   input  logic               blocked_i,
   output logic [PHASE_W-1:0] tw_o,
   output logic [CPB_W-1:0]   cpb_o,
   output logic               sec_o
);

   localparam int unsigned GEN_CPB  = clks_per_bit(GEN_CLK_HZ, GEN_BPS);
   localparam int unsigned UTIL_CPB = clks_per_bit(UTIL_CLK_HZ, UTIL_BPS);

   if (GEN_CPB >= (1 << CPB_W) || UTIL_CPB >= (1 << CPB_W)) begin : g_cpb_bad
      $error("bpsk_tune_sel: CPB_W too narrow for bit period");
   end
   if (GEN_CPB < 2 || UTIL_CPB < 2) begin : g_cpb_short
      $error("bpsk_tune_sel: bit period must span at least two clocks");
   end

   logic [PHASE_W-1:0] tw_tab [4];
   logic [CPB_W-1:0]   cpb_tab [2];

   for (genvar k = 0; k < 4; k++) begin : g_tw
      localparam int unsigned CLK  = (k / 2 == 1) ? GEN_CLK_HZ : UTIL_CLK_HZ;
      localparam int unsigned FREQ = (k == 3) ? GEN_SEC_HZ  :
                                     (k == 2) ? GEN_PRI_HZ  :
                                     (k == 1) ? UTIL_SEC_HZ : UTIL_PRI_HZ;
      assign tw_tab[k] = PHASE_W'(tune_word(FREQ, CLK, PHASE_W));
   end

   assign cpb_tab[0] = CPB_W'(UTIL_CPB);
   assign cpb_tab[1] = CPB_W'(GEN_CPB);

   logic               sec_live;
   logic [PHASE_W-1:0] tw_q;
   logic [CPB_W-1:0]   cpb_q;
   logic               sec_q;

   assign sec_live = car_i | blocked_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tw_q  <= '0;
         cpb_q <= '0;
         sec_q <= 1'b0;
      end else if (load_i) begin
         tw_q  <= tw_tab[{band_i, sec_live}];
         cpb_q <= cpb_tab[band_i];
         sec_q <= sec_live;
      end
   end

   assign tw_o  = tw_q;
   assign cpb_o = load_i ? cpb_tab[band_i] : cpb_q;
   assign sec_o = sec_q;

endmodule

// File: rtl/bpsk_bit_timer.sv
module bpsk_bit_timer #(
   parameter int unsigned CPB_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             valid_i,
   input  logic             data_i,
   input  logic [CPB_W-1:0] cpb_i,
   output logic             ready_o,
   output logic             start_o,
   output logic             busy_o,
   output logic             bit_o
);

   logic             busy_q;
   logic             bit_q;
   logic [CPB_W-1:0] cnt_q;

   assign ready_o = !busy_q || (cnt_q == '0);
   assign start_o = valid_i && !busy_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         bit_q  <= 1'b0;
         cnt_q  <= '0;
      end else if (ready_o) begin
         if (valid_i) begin
            busy_q <= 1'b1;
            bit_q  <= data_i;
            cnt_q  <= cpb_i - 1'b1;
         end else begin
            busy_q <= 1'b0;
         end
      end else begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign busy_o = busy_q;
   assign bit_o  = bit_q;

endmodule

// File: rtl/bpsk_sine_lut.sv
module bpsk_sine_lut
   import bpsk_pkg::*;
#(
   parameter int unsigned PHASE_W  = 24,
   parameter int unsigned ADDR_W   = 6,
   parameter int unsigned SAMPLE_W = 8
) (
   input  logic [PHASE_W-1:0]         phase_i,
   output logic signed [SAMPLE_W-1:0] sample_o
);

   localparam int DEPTH = 1 << ADDR_W;
   localparam int AMP   = (1 << (SAMPLE_W - 1)) - 1;

   if (PHASE_W < ADDR_W + 2) begin : g_bad_w
      $error("bpsk_sine_lut: phase narrower than table address plus quadrant");
   end

   logic [SAMPLE_W-2:0] rom [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_rom
      assign rom[i] = (SAMPLE_W-1)'(quarter_sine(i, DEPTH, AMP));
   end

   logic [1:0]          quad;
   logic [ADDR_W-1:0]   idx;
   logic [ADDR_W-1:0]   addr;
   logic [SAMPLE_W-1:0] mag;

   assign quad = phase_i[PHASE_W-1 -: 2];
   assign idx  = phase_i[PHASE_W-3 -: ADDR_W];
   assign addr = quad[0] ? ~idx : idx;
   assign mag  = {1'b0, rom[addr]};

   assign sample_o = quad[1] ? -$signed(mag) : $signed(mag);

endmodule

// File: rtl/bpsk_dual_tx.sv
module bpsk_dual_tx #(
   parameter int unsigned PHASE_W     = 24,
   parameter int unsigned LUT_ADDR_W  = 6,
   parameter int unsigned SAMPLE_W    = 8,
   parameter int unsigned CPB_W       = 12,
   parameter int unsigned GEN_CLK_HZ  = 10_000_000,
   parameter int unsigned UTIL_CLK_HZ = 6_553_600,
   parameter int unsigned GEN_PRI_HZ  = 132_000,
   parameter int unsigned GEN_SEC_HZ  = 115_000,
   parameter int unsigned UTIL_PRI_HZ = 86_000,
   parameter int unsigned UTIL_SEC_HZ = 75_000,
   parameter int unsigned GEN_BPS     = 5400,
   parameter int unsigned UTIL_BPS    = 3600
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       band_sel,
   input  logic                       car_sel,
   input  logic                       primary_blocked,
   input  logic                       bit_valid,
   input  logic                       bit_data,
   output logic                       bit_ready,
   output logic signed [SAMPLE_W-1:0] dac_sample,
   output logic                       tx_active
);

   logic               start;
   logic               active;
   logic               cur_bit;
   logic [CPB_W-1:0]   cpb_use;
   logic [PHASE_W-1:0] tw_q;
   logic               sec_q;

   bpsk_tune_sel #(
      .PHASE_W    (PHASE_W),
      .CPB_W      (CPB_W),
      .GEN_CLK_HZ (GEN_CLK_HZ),
      .UTIL_CLK_HZ(UTIL_CLK_HZ),
      .GEN_PRI_HZ (GEN_PRI_HZ),
      .GEN_SEC_HZ (GEN_SEC_HZ),
      .UTIL_PRI_HZ(UTIL_PRI_HZ),
      .UTIL_SEC_HZ(UTIL_SEC_HZ),
      .GEN_BPS    (GEN_BPS),
      .UTIL_BPS   (UTIL_BPS)
   ) u_tune (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (start),
      .band_i   (band_sel),
      .car_i    (car_sel),
      .blocked_i(primary_blocked),
      .tw_o     (tw_q),
      .cpb_o    (cpb_use),
      .sec_o    (sec_q)
   );

   bpsk_bit_timer #(.CPB_W(CPB_W)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .valid_i(bit_valid),
      .data_i (bit_data),
      .cpb_i  (cpb_use),
      .ready_o(bit_ready),
      .start_o(start),
      .busy_o (active),
      .bit_o  (cur_bit)
   );

   // Phase accumulator, restarted at each packet
   logic [PHASE_W-1:0] acc_q;
   logic [PHASE_W-1:0] phase;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q <= '0;
      end else if (start) begin
         acc_q <= '0;
      end else if (active) begin
         acc_q <= acc_q + tw_q;
      end
   end

   // A zero bit adds half a cycle: flip the phase MSB
   assign phase = {acc_q[PHASE_W-1] ^ ~cur_bit, acc_q[PHASE_W-2:0]};

   logic signed [SAMPLE_W-1:0] lut_out;

   bpsk_sine_lut #(
      .PHASE_W (PHASE_W),
      .ADDR_W  (LUT_ADDR_W),
      .SAMPLE_W(SAMPLE_W)
   ) u_lut (
      .phase_i (phase),
      .sample_o(lut_out)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dac_sample <= '0;
         tx_active  <= 1'b0;
      end else begin
         dac_sample <= active ? lut_out : '0;
         tx_active  <= active;
      end
   end

endmodule

// File: rtl/bpsk_dual_tx_chk.sv
module bpsk_dual_tx_chk #(
   parameter int unsigned PHASE_W  = 24,
   parameter int unsigned SAMPLE_W = 8
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       primary_blocked,
   input logic                       bit_ready,
   input logic signed [SAMPLE_W-1:0] dac_sample,
   input logic                       tx_active,
   input logic                       active,
   input logic                       start,
   input logic                       cur_bit,
   input logic [PHASE_W-1:0]         tw_q,
   input logic                       sec_q
);

   // R8
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_active |-> dac_sample == '0);

   // R8
   tx_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> tx_active == $past(active));

   // R9
   ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !active |-> bit_ready);

   // R5
   bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !bit_ready) |=> $stable(cur_bit));

   // R7
   carrier_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      active |=> $stable(tw_q));

   // R6
   blocked_sec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && primary_blocked) |=> sec_q);

   // R10
   no_min_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dac_sample != {1'b1, {(SAMPLE_W-1){1'b0}}});

endmodule

bind bpsk_dual_tx bpsk_dual_tx_chk #(
   .PHASE_W (PHASE_W),
   .SAMPLE_W(SAMPLE_W)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .primary_blocked(primary_blocked),
   .bit_ready      (bit_ready),
   .dac_sample     (dac_sample),
   .tx_active      (tx_active),
   .active         (active),
   .start          (start),
   .cur_bit        (cur_bit),
   .tw_q           (tw_q),
   .sec_q          (sec_q)
);

// File: tb/tb_bpsk_dual_tx.sv
`timescale 1ns/1ps
module tb_bpsk_dual_tx;

   localparam int  GEN_CPB  = 1852;
   localparam int  UTIL_CPB = 1820;
   localparam real GEN_CLK  = 10.0e6;
   localparam real UTIL_CLK = 6.5536e6;
   localparam real TWO_PI   = 6.283185307179586;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              band_sel, car_sel, primary_blocked;
   logic              bit_valid, bit_data;
   logic              bit_ready;
   logic signed [7:0] dac_sample;
   logic              tx_active;

   int n_checks = 0;
   int n_fail   = 0;

   always #4 clk = ~clk;

   bpsk_dual_tx dut (
      .clk            (clk),
      .rst_n          (rst_n),
      .band_sel       (band_sel),
      .car_sel        (car_sel),
      .primary_blocked(primary_blocked),
      .bit_valid      (bit_valid),
      .bit_data       (bit_data),
      .bit_ready      (bit_ready),
      .dac_sample     (dac_sample),
      .tx_active      (tx_active)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic real ref_sample(input int n, input real ratio, input bit b);
      real ph;
      ph = n * ratio + (b ? 0.0 : 0.5);
      ph = ph - $floor(ph);
      return 127.0 * $sin(TWO_PI * ph);
   endfunction

   // Send nb bits (LSB first of pat), check every sample, the handshake and length
   task automatic run_packet(input string req, input bit band, input bit car,
                             input bit blk, input int nb, input logic [7:0] pat,
                             input real ratio, input int cpb, input bit toggle);
      int  total;
      int  smax;
      int  smin;
      real e;
      total = nb * cpb;
      smax  = -200;
      smin  = 200;
      @(negedge clk);
      band_sel        = band;
      car_sel         = car;
      primary_blocked = blk;
      bit_valid       = 1'b1;
      bit_data        = pat[0];
      @(posedge clk);
      for (int n = 0; n <= total; n++) begin
         @(negedge clk);
         if (n < total && n % cpb == 0) begin
            if (n / cpb + 1 < nb) bit_data = pat[n / cpb + 1];
            else bit_valid = 1'b0;
         end
         if (toggle && n == cpb / 2) begin
            band_sel        = ~band;
            car_sel         = ~car;
            primary_blocked = 1'b1;
         end
         if (n < total && (n % cpb == cpb - 1 || n % cpb == cpb / 2))
            check(bit_ready == (n % cpb == cpb - 1), "R9", "bit_ready in bit",
                  int'(bit_ready), int'(n % cpb == cpb - 1));
         if (n >= 1) begin
            e = ref_sample(n - 1, ratio, pat[(n - 1) / cpb]);
            check(($itor(dac_sample) - e) <= 3.0 && (e - $itor(dac_sample)) <= 3.0,
                  req, "sample", int'(dac_sample), $rtoi(e));
            check(tx_active == 1'b1, "R8", "tx_active in packet", int'(tx_active), 1);
            if (int'(dac_sample) > smax) smax = int'(dac_sample);
            if (int'(dac_sample) < smin) smin = int'(dac_sample);
         end else begin
            check(tx_active == 1'b0, "R8", "first-sample delay", int'(tx_active), 0);
         end
      end
      @(negedge clk);
      check(tx_active == 1'b0, "R8", "tx_active after packet", int'(tx_active), 0);
      check(dac_sample == 8'sd0, "R8", "silent after packet", int'(dac_sample), 0);
      check(bit_ready == 1'b1, "R9", "ready when idle", int'(bit_ready), 1);
      check(smax >= 124 && smax <= 127, "R10", "positive peak", smax, 127);
      check(smin <= -124 && smin >= -127, "R10", "negative peak", smin, -127);
      band_sel        = band;
      car_sel         = car;
      primary_blocked = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic t_reset();
      rst_n           = 1'b0;
      bit_valid       = 1'b0;
      bit_data        = 1'b0;
      band_sel        = 1'b1;
      car_sel         = 1'b0;
      primary_blocked = 1'b0;
      repeat (4) @(posedge clk);
      @(negedge clk);
      check(tx_active == 1'b0, "R1", "tx_active in reset", int'(tx_active), 0);
      check(dac_sample == 8'sd0, "R1", "sample in reset", int'(dac_sample), 0);
      check(bit_ready == 1'b1, "R1", "ready in reset", int'(bit_ready), 1);
      rst_n = 1'b1;
      @(negedge clk);
      check(tx_active == 1'b0 && dac_sample == 8'sd0, "R1", "idle after reset",
            int'(tx_active), 0);
   endtask

   // R2 and R5: 1,0,0,1 exercises a flip and a held zero
   task automatic t_general_primary();
      run_packet("R2", 1'b1, 1'b0, 1'b0, 4, 8'b1001, 132.0e3 / GEN_CLK, GEN_CPB, 1'b0);
   endtask

   // R3 with R5: 0,1,1,0
   task automatic t_general_secondary();
      run_packet("R3", 1'b1, 1'b1, 1'b0, 4, 8'b0110, 115.0e3 / GEN_CLK, GEN_CPB, 1'b0);
   endtask

   // R4: both utility carriers and the 1820-clock bit
   task automatic t_utility();
      run_packet("R4", 1'b0, 1'b0, 1'b0, 3, 8'b101, 86.0e3 / UTIL_CLK, UTIL_CPB, 1'b0);
      run_packet("R4", 1'b0, 1'b1, 1'b0, 3, 8'b010, 75.0e3 / UTIL_CLK, UTIL_CPB, 1'b0);
   endtask

   // R6: blocked primary falls back to the secondary carrier
   task automatic t_blocked();
      run_packet("R6", 1'b1, 1'b0, 1'b1, 2, 8'b01, 115.0e3 / GEN_CLK, GEN_CPB, 1'b0);
   endtask

   // R7: selectors change mid-packet, the packet keeps its carrier and bit length
   task automatic t_latched();
      run_packet("R7", 1'b1, 1'b0, 1'b0, 3, 8'b100, 132.0e3 / GEN_CLK, GEN_CPB, 1'b1);
   endtask

   initial begin
      t_reset();
      t_general_primary();
      t_general_secondary();
      t_utility();
      t_blocked();
      t_latched();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule